// File: doc/BRIEF.md
# CPU Interrupt and Reset Sequencer

This block is the control logic inside a processor that decides when a pending interrupt is accepted and what the program counter starts from after reset. It watches a shared, level-sensitive interrupt line and takes the interrupt only at safe points. When the bus is idle, a safe point can occur on any cycle. While a bus transaction is in progress, the only safe point is the cycle in which that transaction completes, so a transaction is never split. In both cases the pipeline must also report an instruction boundary.

Accepting an interrupt produces a one-cycle forced branch-and-link request and a matching pipeline squash pulse. It also presents the fixed service vector and clears the interrupt-enable flag in that same cycle. A return-from-interrupt decode sets the flag again.

A host run bit arrives from another clock domain. It passes through a flip-flop synchronizer and gates execution after reset, and no interrupt is taken while execution is not enabled. The program counter's reset value is a 22-bit word address of zero.

Top module: `irqseq_top`

## Requirements
- R1: With the bus idle (`bus_busy_i`=0), an interrupt is accepted on any cycle where `irq_i`=1, `ie_o`=1, `run_en_o`=1 and `insn_boundary_i`=1. `take_irq_o` is high in the cycle after the edge that samples those inputs.
- R2: While `bus_busy_i`=1, an interrupt is accepted only in a cycle with `bus_done_i`=1. A cycle with `bus_busy_i`=1 and `bus_done_i`=0 never leads to `take_irq_o`.
- R3: No interrupt is accepted while `ie_o`=0, whatever `irq_i` does.
- R4: An accepted interrupt gives exactly one cycle of `take_irq_o`=1 and `squash_o`=1. In that same cycle `vector_o` reads 0x000008 and `ie_o` reads 0.
- R5: A cycle with `rti_i`=1 sets `ie_o` to 1 from the next cycle on, so that a later interrupt can be accepted.
- R6: After a clock edge with `rst_n`=0: `ie_o`=1, `take_irq_o`=0, `squash_o`=0, `run_en_o`=0, and `pc_reset_o` reads 22'h000000 (a word address, byte address bits [1:0] implied zero).
- R7: `run_en_o` follows `host_run_i` through two flip-flops, so a change is seen after the second rising edge. No interrupt is accepted while `run_en_o`=0.
- R8: No interrupt is accepted in a cycle with `insn_boundary_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | Shared interrupt request line, level sensitive |
| bus_busy_i | input | 1 | A bus transaction is in progress |
| bus_done_i | input | 1 | The current bus transaction completes in this cycle |
| insn_boundary_i | input | 1 | Pipeline is at an instruction boundary |
| rti_i | input | 1 | Return-from-interrupt decoded |
| host_run_i | input | 1 | Asynchronous host run bit |
| take_irq_o | output | 1 | Forced branch-and-link request, one-cycle pulse |
| vector_o | output | 24 | Service vector byte address (0x000008) |
| squash_o | output | 1 | Pipeline squash pulse |
| ie_o | output | 1 | Interrupt-enable flag |
| run_en_o | output | 1 | Synchronized run enable |
| pc_reset_o | output | 22 | Program counter reset value (word address) |

## Verification
Acceptance is tried in several settings. The first is an idle bus with the request held high, which shows that sampling happens on every cycle. The second is a transaction held open for several cycles before it completes, which separates the completion cycle from the cycles in the middle. Requests are also raised with the enable flag low, without an instruction boundary, and before the run bit has crossed the synchronizer. Each of these must give no pulse, and together they show that every qualifier is actually used. A return-from-interrupt followed by a second request shows that the enable flag was re-armed and that the pulse repeats cleanly.

// File: rtl/irqseq_pkg.sv
// Package: shared widths and constants for the interrupt/reset sequencer.
// Assumes byte addressing on a 24-bit bus and word-aligned instructions.
package irqseq_pkg;
    localparam int unsigned BUS_AW      = 24;
    localparam int unsigned WORD_SHIFT  = 2;
    localparam int unsigned PC_BITS     = BUS_AW - WORD_SHIFT;
    localparam logic [BUS_AW-1:0] SVC_VECTOR = 24'h000008;
endpackage

// File: rtl/irqseq_run_sync.sv
// Module: multi-flop synchronizer for the host run bit.
// Assumes STAGES >= 2; the chain clears on synchronous reset, so the
// run enable stays low while reset is asserted.
module irqseq_run_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the asynchronous bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_i};
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/irqseq_sample_gate.sv
// Module: decides whether this cycle is a legal interrupt sampling point.
// Assumes bus_done_i is only meaningful while bus_busy_i is high.
module irqseq_sample_gate (
    input  logic bus_busy_i,
    input  logic bus_done_i,
    input  logic insn_boundary_i,
    output logic sample_ok_o
);
    // Idle bus: any boundary cycle; busy bus: only the completion cycle.
    always_comb begin
        if (bus_busy_i) sample_ok_o = insn_boundary_i & bus_done_i;
        else            sample_ok_o = insn_boundary_i;
    end
endmodule

// File: rtl/irqseq_take_ctrl.sv
// Module: interrupt-enable flag and the accept pulse.
// Assumes the request line is level sensitive and held until serviced.
// Acceptance clears the enable in the same cycle the pulse is issued.
module irqseq_take_ctrl #(
    parameter bit IE_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic sample_ok_i,
    input  logic run_en_i,
    input  logic rti_i,
    output logic take_o,
    output logic ie_o
);
    logic fire;
    logic take_q;
    logic ie_q;

    // Accept when requested, enabled, running and at a legal point.
    always_comb fire = irq_i & ie_q & run_en_i & sample_ok_i;

    // Register the pulse and update the enable flag (accept wins over return).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            ie_q   <= IE_RESET;
        end else begin
            take_q <= fire;
            if (fire)       ie_q <= 1'b0;
            else if (rti_i) ie_q <= 1'b1;
        end
    end

    assign take_o = take_q;
    assign ie_o   = ie_q;

    AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(ie_q)); // R3
    AST_IE_CLEARED_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> !ie_q); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |=> !take_q); // R4
    AST_RTI_ARMS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && !fire) |=> ie_q); // R5
    AST_TAKE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(run_en_i)); // R7
endmodule

// File: rtl/irqseq_top.sv
// Module: CPU interrupt and reset sequencer top.
// Samples the interrupt line at safe points, issues a forced
// branch-and-link with squash, and supplies the reset PC and run enable.
// Assumes synchronous active-low reset and a single CPU clock.
module irqseq_top
    import irqseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          IE_RESET    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_i,
    input  logic               bus_busy_i,
    input  logic               bus_done_i,
    input  logic               insn_boundary_i,
    input  logic               rti_i,
    input  logic               host_run_i,
    output logic               take_irq_o,
    output logic [BUS_AW-1:0]  vector_o,
    output logic               squash_o,
    output logic               ie_o,
    output logic               run_en_o,
    output logic [PC_BITS-1:0] pc_reset_o
);
    logic sample_ok;
    logic run_en;
    logic take;

    irqseq_run_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_run_i),
        .sync_o  (run_en)
    );

    irqseq_sample_gate u_gate (
        .bus_busy_i      (bus_busy_i),
        .bus_done_i      (bus_done_i),
        .insn_boundary_i (insn_boundary_i),
        .sample_ok_o     (sample_ok)
    );

    irqseq_take_ctrl #(.IE_RESET(IE_RESET)) u_take (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .sample_ok_i (sample_ok),
        .run_en_i    (run_en),
        .rti_i       (rti_i),
        .take_o      (take),
        .ie_o        (ie_o)
    );

    // Drive the outputs: pulse pair, fixed vector and zero reset PC.
    assign take_irq_o = take;
    assign squash_o   = take;
    assign vector_o   = SVC_VECTOR;
    assign run_en_o   = run_en;
    assign pc_reset_o = '0;

    AST_NO_MID_TXN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> $past(!bus_busy_i || bus_done_i)); // R2
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |-> $past(insn_boundary_i)); // R8
    AST_SQUASH_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> (take_irq_o && vector_o == 24'h000008)); // R4
endmodule

// File: tb/irqseq_top_tb_top.sv
module irqseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, irq, busy, done, bnd, rti, hrun;
    logic        take, squash, ie, run_en;
    logic [23:0] vec;
    logic [21:0] pcr;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    irqseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_busy_i(busy),
        .bus_done_i(done), .insn_boundary_i(bnd), .rti_i(rti),
        .host_run_i(hrun), .take_irq_o(take), .vector_o(vec),
        .squash_o(squash), .ie_o(ie), .run_en_o(run_en), .pc_reset_o(pcr)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        irq = 0; busy = 0; done = 0; bnd = 0; rti = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; hrun = 1; idle_inputs();
        step(); step(); step();
        check(ie, 1, "R6 ie");
        check(take, 0, "R6 take");
        check(squash, 0, "R6 squash");
        check(run_en, 0, "R6 run_en low in reset");
        check(pcr, 0, "R6 pc_reset");
        hrun = 0; rst_n = 1; step();
    endtask

    task automatic t_run_sync();
        irq = 1; bnd = 1;
        step(); check(take, 0, "R7 no take while not running");
        hrun = 1; step();
        check(run_en, 0, "R7 after one edge");
        irq = 0; step();
        check(run_en, 1, "R7 after two edges");
        check(take, 0, "R7 no take before run");
    endtask

    task automatic t_idle_take();
        irq = 1; bnd = 1; step();
        check(take, 1, "R1 idle take");
        check(squash, 1, "R4 squash");
        check(vec, 32'h8, "R4 vector");
        check(ie, 0, "R4 ie cleared");
        irq = 0; step();
        check(take, 0, "R4 single pulse");
    endtask

    task automatic t_ie_block();
        irq = 1; bnd = 1; step(); step();
        check(take, 0, "R3 blocked while ie=0");
        irq = 0; rti = 1; step();
        rti = 0;
        check(ie, 1, "R5 rti sets ie");
        check(take, 0, "R5 no take");
    endtask

    task automatic t_boundary();
        irq = 1; bnd = 0; step(); step();
        check(take, 0, "R8 no boundary");
        check(ie, 1, "R8 ie kept");
        bnd = 1; step();
        check(take, 1, "R8 take at boundary");
        irq = 0; rti = 1; step(); rti = 0;
        check(ie, 1, "R5 rearm");
    endtask

    task automatic t_bus();
        irq = 1; bnd = 1; busy = 1; done = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            check(take, 0, "R2 mid transaction");
        end
        done = 1; step();
        check(take, 1, "R2 take at completion");
        idle_inputs(); rti = 1; step(); rti = 0;
        check(ie, 1, "R5 rearm after bus");
    endtask

    task automatic t_run_drop();
        hrun = 0; step(); step();
        check(run_en, 0, "R7 run drop");
        irq = 1; bnd = 1; step();
        check(take, 0, "R7 no take when stopped");
        idle_inputs();
    endtask

    initial begin
        t_reset();
        t_run_sync();
        t_idle_take();
        t_ie_block();
        t_boundary();
        t_bus();
        t_run_drop();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule